// File: doc/BRIEF.md
# Sparse Three-Tap Droop Compensator

This block is a streaming FIR filter that flattens the passband sag left by a cascaded integrator-comb stage. It sits directly behind a three-stage CIC running at the high sample rate. It computes y[n] = (x[n] + c·x[n−I] + x[n−2I]) / (c + 2) on signed samples that arrive with a valid strobe. The taps sit at delays 0, I and 2·I, where I = H·R: R is the CIC rate factor and H is a small positive integer.

The centre coefficient c is large and negative. The normalizing divisor 1/(c+2) is stored as a signed fractional constant. The datapath keeps the three-way sum at full precision. It then multiplies by the normalizer and drops the fractional bits with round-half-up. Results that fall outside the output range are clipped to the largest positive or negative code.

With the defaults, I = 5, c = −5.592 and c+2 = −3.592. The delay line therefore holds ten past samples.

Top module: `cic_droop_comp`

## Requirements
- R1: For each accepted sample the block computes S = x[n]·2^COEF_FRAC + C_Q·x[n−I] + x[n−2I]·2^COEF_FRAC at full precision. It then forms P = S·NORM_Q and outputs (P + 2^(SH−1)) >>> SH, where SH = COEF_FRAC + NORM_FRAC and >>> is an arithmetic shift.
- R2: The tap spacing I equals H·R. The output depends only on the samples accepted 0, I and 2·I strobes earlier.
- R3: The delay line moves forward only on cycles where in_valid is 1. Idle cycles between samples do not change any output value.
- R4: out_valid is in_valid delayed by exactly 3 clock cycles. out_data keeps its last value while out_valid is 0.
- R5: Bits discarded by the final shift are rounded half-up. With the defaults, a single input of 1 gives 0 at delay 0 and 2 at delay I.
- R6: When the rounded result is above 2^(OUT_W−1)−1 or below −2^(OUT_W−1), out_data is that limit. The output never wraps.
- R7: A synchronous active-high rst clears the delay line and the pipeline, and sets out_valid and out_data to 0. Outputs after reset treat every missing past sample as zero.
- R8: The default constants are C_Q = −22905 (c with 12 fractional bits) and NORM_Q = −9123 (1/(c+2) in Q1.15), with H = 1 and R = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | OUT_W | Signed compensated sample |

## Verification
The scoreboard model works only from the equation in R1. It is driven with three stimuli:
- A small impulse of amplitude 1. A design that truncates instead of rounding gives −1 instead of 0 at the first tap, and 1 instead of 2 at the centre tap.
- A larger impulse with idle gaps. A delay line that shifts on every cycle places the centre and far taps at the wrong samples.
- Full-scale alternating data in both phases. Wrapping arithmetic flips the sign of the saturated result.

A reset applied mid-stream, after a DC run, exposes a delay line that keeps stale samples. The bench also measures the strobe latency and checks that out_data is held between strobes.

// File: rtl/cic_droop_pkg.sv
package cic_droop_pkg;

    // Default numeric format of the datapath
    localparam int DEF_IN_W      = 16;
    localparam int DEF_OUT_W     = 16;
    localparam int DEF_COEF_W    = 16;
    localparam int DEF_NORM_W    = 16;
    localparam int DEF_COEF_FRAC = 12;
    localparam int DEF_NORM_FRAC = 15;

    // Default spacing: small multiplier times CIC rate factor
    localparam int DEF_H = 1;
    localparam int DEF_R = 5;

    // Quantized constants: c = -5.592 in Q.12, 1/(c+2) in Q1.15
    localparam int DEF_C_Q    = -22905;
    localparam int DEF_NORM_Q = -9123;

    // Clock cycles from an accepted sample to its result
    localparam int PIPE_LAT = 3;

    // Guard bits on the three-way sum
    localparam int SUM_GUARD = 2;

    function automatic int tap_span(input int h, input int r);
        return h * r;
    endfunction

    function automatic int sum_width(input int in_w, input int coef_w);
        return in_w + coef_w + SUM_GUARD;
    endfunction

    // Pipeline position tags, used for readability of stage control
    typedef enum logic [1:0] {
        ST_TAP   = 2'd0,
        ST_SUM   = 2'd1,
        ST_SCALE = 2'd2,
        ST_DONE  = 2'd3
    } pipe_stage_e;

endpackage

// File: rtl/sc_tap_line.sv
module sc_tap_line #(
    parameter int W    = 16,
    parameter int SPAN = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] tap_now,
    output logic signed [W-1:0] tap_mid,
    output logic signed [W-1:0] tap_far
);
    localparam int DEPTH = 2 * SPAN;

    logic signed [W-1:0] line_q [DEPTH];

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_cell
            if (k == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)
                        line_q[k] <= '0;
                    else if (adv)
                        line_q[k] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst)
                        line_q[k] <= '0;
                    else if (adv)
                        line_q[k] <= line_q[k-1];
                end
            end
        end
    endgenerate

    assign tap_now = din;
    assign tap_mid = line_q[SPAN-1];
    assign tap_far = line_q[DEPTH-1];

    // R3: the line is frozen on cycles without a strobe
    p_line_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(line_q[0]) && $stable(line_q[DEPTH-1])));

    // R3: an accepted sample lands in the head cell
    p_line_load_r3: assert property (@(posedge clk) disable iff (rst)
        adv |=> (line_q[0] == $past(din)));

endmodule

// File: rtl/sc_tap_mac.sv
module sc_tap_mac #(
    parameter int IN_W      = 16,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 12,
    parameter int C_Q       = -22905,
    parameter int ACC_W     = 34
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vin,
    input  logic signed [IN_W-1:0]  x_now,
    input  logic signed [IN_W-1:0]  x_mid,
    input  logic signed [IN_W-1:0]  x_far,
    output logic                    vout,
    output logic signed [ACC_W-1:0] sum_q
);
    localparam logic signed [COEF_W-1:0] C_K = COEF_W'(C_Q);

    // Stage 1: weighting of the three taps
    logic signed [ACC_W-1:0] w_now_d, w_mid_d, w_far_d;
    logic signed [ACC_W-1:0] w_now_q, w_mid_q, w_far_q;
    logic                    v1_q;

    always_comb begin
        w_now_d = ACC_W'(x_now) <<< COEF_FRAC;
        w_far_d = ACC_W'(x_far) <<< COEF_FRAC;
        w_mid_d = ACC_W'(x_mid) * ACC_W'(C_K);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_now_q <= '0;
            w_mid_q <= '0;
            w_far_q <= '0;
            v1_q    <= 1'b0;
        end else begin
            w_now_q <= w_now_d;
            w_mid_q <= w_mid_d;
            w_far_q <= w_far_d;
            v1_q    <= vin;
        end
    end

    // Stage 2: three-way sum at full precision
    logic signed [ACC_W-1:0] sum_d;
    assign sum_d = w_now_q + w_mid_q + w_far_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            vout  <= 1'b0;
        end else begin
            sum_q <= sum_d;
            vout  <= v1_q;
        end
    end

    // R1: all-zero taps produce a zero sum two stages later
    p_zero_sum_r1: assert property (@(posedge clk) disable iff (rst)
        (x_now == '0 && x_mid == '0 && x_far == '0) |=> ##1 (sum_q == '0));

    // R1: the outer taps enter with equal weight
    p_outer_sym_r1: assert property (@(posedge clk) disable iff (rst)
        (x_now == x_far && x_mid == '0) |=> (w_now_q == w_far_q && w_mid_q == '0));

endmodule

// File: rtl/sc_norm_sat.sv
module sc_norm_sat #(
    parameter int ACC_W     = 34,
    parameter int NORM_W    = 16,
    parameter int NORM_Q    = -9123,
    parameter int SHIFT     = 27,
    parameter int OUT_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vin,
    input  logic signed [ACC_W-1:0] sum_in,
    output logic                    vout,
    output logic signed [OUT_W-1:0] dout
);
    localparam int PROD_W = ACC_W + NORM_W;

    localparam logic signed [NORM_W-1:0] N_K  = NORM_W'(NORM_Q);
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (SHIFT - 1);
    localparam logic signed [PROD_W-1:0] MAXV =
        {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] MINV =
        {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rounded;
    logic signed [PROD_W-1:0] shifted;
    logic signed [OUT_W-1:0]  clipped;

    always_comb begin
        prod    = PROD_W'(sum_in) * PROD_W'(N_K);
        rounded = prod + HALF;
        shifted = rounded >>> SHIFT;
        if (shifted > MAXV)
            clipped = MAXV[OUT_W-1:0];
        else if (shifted < MINV)
            clipped = MINV[OUT_W-1:0];
        else
            clipped = shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            vout <= 1'b0;
        end else begin
            vout <= vin;
            if (vin)
                dout <= clipped;
        end
    end

    // R4: the result is held between strobes
    p_hold_out_r4: assert property (@(posedge clk) disable iff (rst)
        !vin |=> $stable(dout));

    // R6: a negative normalizer never turns a positive sum into a positive output
    p_sign_sense_r6: assert property (@(posedge clk) disable iff (rst)
        (vin && N_K < 0 && sum_in > 0) |=> (dout <= 0));

endmodule

// File: rtl/cic_droop_comp.sv
module cic_droop_comp
    import cic_droop_pkg::*;
#(
    parameter int IN_W      = DEF_IN_W,
    parameter int OUT_W     = DEF_OUT_W,
    parameter int COEF_W    = DEF_COEF_W,
    parameter int NORM_W    = DEF_NORM_W,
    parameter int COEF_FRAC = DEF_COEF_FRAC,
    parameter int NORM_FRAC = DEF_NORM_FRAC,
    parameter int H         = DEF_H,
    parameter int R         = DEF_R,
    parameter int C_Q       = DEF_C_Q,
    parameter int NORM_Q    = DEF_NORM_Q
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int SPAN  = tap_span(H, R);
    localparam int ACC_W = sum_width(IN_W, COEF_W);
    localparam int SHIFT = COEF_FRAC + NORM_FRAC;

    logic signed [IN_W-1:0]  tap_now, tap_mid, tap_far;
    logic                    sum_v;
    logic signed [ACC_W-1:0] sum_w;

    sc_tap_line #(
        .W    (IN_W),
        .SPAN (SPAN)
    ) u_line (
        .clk     (clk),
        .rst     (rst),
        .adv     (in_valid),
        .din     (in_data),
        .tap_now (tap_now),
        .tap_mid (tap_mid),
        .tap_far (tap_far)
    );

    sc_tap_mac #(
        .IN_W      (IN_W),
        .COEF_W    (COEF_W),
        .COEF_FRAC (COEF_FRAC),
        .C_Q       (C_Q),
        .ACC_W     (ACC_W)
    ) u_mac (
        .clk   (clk),
        .rst   (rst),
        .vin   (in_valid),
        .x_now (tap_now),
        .x_mid (tap_mid),
        .x_far (tap_far),
        .vout  (sum_v),
        .sum_q (sum_w)
    );

    sc_norm_sat #(
        .ACC_W  (ACC_W),
        .NORM_W (NORM_W),
        .NORM_Q (NORM_Q),
        .SHIFT  (SHIFT),
        .OUT_W  (OUT_W)
    ) u_norm (
        .clk    (clk),
        .rst    (rst),
        .vin    (sum_v),
        .sum_in (sum_w),
        .vout   (out_valid),
        .dout   (out_data)
    );

    // Cycles since reset, saturating at the pipeline latency
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'(PIPE_LAT))
            since_rst <= since_rst + 2'd1;
    end

    // R4: fixed strobe latency, once the pipeline has refilled after reset
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'(PIPE_LAT)) |-> (out_valid == $past(in_valid, 3)));

    // R7: reset empties the output stage
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/cic_droop_comp_tb.sv
module cic_droop_comp_tb;
    localparam int IN_W = 16;
    localparam int OUT_W = 16;
    localparam int SPAN = 5;
    localparam longint CQ = -22905;
    localparam longint NQ = -9123;
    localparam int SH = 27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_data = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    longint hist [2*SPAN+1];
    longint exp_q [$];
    string  tag_q [$];
    longint last_out = 0;

    always #5 clk = ~clk;

    cic_droop_comp u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint model_step(input longint x);
        longint s, p, r;
        for (int k = 2*SPAN; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        s = (hist[0] + hist[2*SPAN]) * 4096 + CQ * hist[SPAN];
        p = s * NQ;
        r = (p + (64'sd1 <<< (SH-1))) >>> SH;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic clear_model();
        for (int k = 0; k <= 2*SPAN; k++) hist[k] = 0;
    endtask

    // Driver: one strobe, expected value pushed to the scoreboard
    task automatic send(input longint x, input string tag);
        in_valid = 1'b1;
        in_data  = IN_W'(x);
        exp_q.push_back(model_step(x));
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare on every output strobe
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected strobe", 1, 0);
            end else begin
                check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
            last_out = out_data;
        end
    end

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        clear_model();
        idle(3);
        check("R7 reset out_valid", out_valid, 0);
        check("R7 reset out_data", out_data, 0);
        rst = 1'b0;
        idle(2);

        // R5: rounding of a unit impulse (0 at tap 0, 2 at centre)
        send(1, "R5 unit impulse");
        for (int k = 0; k < 2*SPAN + 2; k++) send(0, "R5 unit impulse tail");
        idle(5);

        // R4: strobe latency measured at the ports
        in_valid = 1'b1;
        in_data  = '0;
        exp_q.push_back(model_step(0));
        tag_q.push_back("R4 latency data");
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check("R4 latency cycles", lat, 3);
        idle(5);

        // R2/R3: impulse with idle gaps between strobes
        send(1000, "R2 impulse");
        for (int k = 0; k < 2*SPAN + 3; k++) begin
            idle(k % 3);
            send(0, "R3 gapped impulse");
        end
        idle(5);

        // R1: DC step
        for (int k = 0; k < 20; k++) send(1000, "R1 dc step");
        idle(5);

        // R6: full-scale alternating, both phases
        for (int k = 0; k < 24; k++) send((k % 2 == 0) ? 32767 : -32768, "R6 alternating");
        for (int k = 0; k < 24; k++) send((k % 2 == 0) ? -32768 : 32767, "R6 alternating inv");
        idle(5);

        // R8/R1: mixed values back to back
        for (int k = 0; k < 30; k++) send(((k * 7919) % 20000) - 10000, "R8 mixed");
        idle(6);

        // R4: held output while idle
        check("R4 hold value", out_data, last_out);
        check("R4 no strobe when idle", out_valid, 0);

        // R7: mid-stream reset after a DC run
        for (int k = 0; k < 12; k++) send(1000, "R7 pre-reset dc");
        idle(6);
        rst = 1'b1;
        idle(2);
        check("R7 mid reset out_valid", out_valid, 0);
        check("R7 mid reset out_data", out_data, 0);
        clear_model();
        rst = 1'b0;
        idle(1);
        send(700, "R7 fresh start");
        for (int k = 0; k < 2*SPAN + 1; k++) send(0, "R7 zero history");
        idle(6);
        check("R4 scoreboard drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule